// File: doc/BRIEF.md
# Bridge Transaction Ordering Queue

This block handles one direction of a two-port bus bridge. The initiator-side target logic hands it one transaction descriptor at a time: a 4-bit bus command, an address, byte enables and one data word. The block sorts the command into one of two classes. Memory writes are posted: they are stored and acknowledged at once. I/O and configuration writes, and every read, are delayed: the initiator is told to retry, and the request is kept until the target bus has finished it. The answer to the initiator is combinational, in the same cycle as `in_valid`.

On the target side the block presents one transaction at a time on a valid/ready stream, in an order that keeps producer/consumer data coherent. A delayed request is issued only after every older posted write has left the block. When the target returns its completion, the result is held until the initiator repeats the same command, address and byte enables. It is then handed back once and the slot is freed. Writes are never combined, and byte enables of separate writes are never merged.

Back-pressure rules: a transaction moves on the target side only in a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the presented descriptor stays unchanged and `out_valid` stays high. The initiator side has no back-pressure signal. Its `in_resp` code is the accept/retry decision.

Top module: `bridge_order_queue`

## Requirements
- R1: Commands 4'b0111 (memory write) and 4'b1111 (memory write and invalidate) are posted. When the posted store has room, `in_resp` is 2'b01 (accept) in the same cycle and the write is queued.
- R2: Commands 4'b0011 (I/O write) and 4'b1011 (configuration write) are delayed writes. A first presentation gets `in_resp` 2'b10 (retry), and the request is queued for the target side.
- R3: Commands 4'b0010, 4'b0110, 4'b1010, 4'b1100 and 4'b1110 are delayed reads. A first presentation gets retry (2'b10), and the request is queued.
- R4: Any other command gets `in_resp` 2'b00 and queues nothing.
- R5: Each posted write leaves on the target side as its own transaction, with its own address, byte enables and data, in arrival order. Two masked writes to the same word stay separate.
- R6: A delayed request is issued only after all posted writes that arrived before it have been issued. It goes ahead of posted writes that arrived after it, if it is eligible while they wait. Delayed requests are issued in arrival order among themselves.
- R7: A posted write is accepted while an earlier delayed request is still queued or outstanding. It may leave on the target side before that request.
- R8: A repeated delayed request whose command, address and byte enables match a completed entry gets `in_resp` 2'b11 (done). It carries the completion data on `in_rdata` and the completion error on `in_err`. This happens exactly once: the next identical request is treated as new and gets retry.
- R9: A repeated delayed request that matches an entry not yet completed gets retry and adds no second entry.
- R10: When the posted store is full, a new posted write gets retry and is not queued.
- R11: When every delayed slot is in use, a new delayed request gets retry and is not queued.
- R12: After reset `out_valid` is low. While `out_valid` is high and `out_ready` is low, the descriptor and `out_valid` stay unchanged.
- R13: At most one delayed request is outstanding on the target side. A `cpl_valid` pulse completes that request, and a pulse with none outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Initiator presents a transaction this cycle |
| in_cmd | input | 4 | Bus command code |
| in_addr | input | ADDR_W | Transaction address |
| in_be | input | BE_W | Byte enables, active high |
| in_data | input | DATA_W | Write data word |
| in_resp | output | 2 | 00 none, 01 accept, 10 retry, 11 done |
| in_rdata | output | DATA_W | Completion data when `in_resp` is done |
| in_err | output | 1 | Completion error when `in_resp` is done |
| out_valid | output | 1 | Target-side transaction presented |
| out_ready | input | 1 | Target-side master takes the transaction |
| out_cmd | output | 4 | Command of the presented transaction |
| out_addr | output | ADDR_W | Address of the presented transaction |
| out_be | output | BE_W | Byte enables of the presented transaction |
| out_data | output | DATA_W | Data of the presented transaction |
| cpl_valid | input | 1 | Target finished the outstanding delayed request |
| cpl_data | input | DATA_W | Read data from the target |
| cpl_err | input | 1 | Target reported an error |

## Verification
A wrong barrier count would let a delayed request out ahead of an older memory write, or hold it back behind a younger one. Either fault shows as a misordered descriptor on the very next target-side handshake. A wrong entry state would show as a repeated request answered done too early, answered twice, or never answered. Each of these appears on `in_resp` at the first re-presentation. A fault in the stall lock would change the descriptor presented under back-pressure within one cycle of the completion that unblocks a delayed request.

// File: rtl/boq_pkg.sv
package boq_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  typedef enum logic [1:0] {
    RSP_NONE   = 2'b00,
    RSP_ACCEPT = 2'b01,
    RSP_RETRY  = 2'b10,
    RSP_DONE   = 2'b11
  } rsp_e;

  typedef enum logic [1:0] {
    ST_FREE   = 2'b00,
    ST_PEND   = 2'b01,
    ST_ISSUED = 2'b10,
    ST_DONE   = 2'b11
  } slot_e;

  typedef struct packed {
    logic [3:0]        cmd;
    logic [ADDR_W-1:0] addr;
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] data;
  } desc_t;
endpackage

// File: rtl/boq_classify.sv
module boq_classify (
  input  logic [3:0] cmd,
  output logic       is_posted,
  output logic       is_delayed
);
  always_comb begin
    is_posted  = 1'b0;
    is_delayed = 1'b0;
    case (cmd)
      4'b0111, 4'b1111:                            is_posted  = 1'b1;
      4'b0011, 4'b1011:                            is_delayed = 1'b1;
      4'b0010, 4'b0110, 4'b1010, 4'b1100, 4'b1110: is_delayed = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/boq_post_fifo.sv
module boq_post_fifo
  import boq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  desc_t         push_d,
  input  logic          pop,
  output logic          nonempty,
  output logic          full,
  output desc_t         head,
  output logic [CW-1:0] count
);
  desc_t          mem [DEPTH];
  logic [PW-1:0]  wp, rp;

  assign nonempty = (count != '0);
  assign full     = (count == CW'(DEPTH));
  assign head     = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wp] <= push_d;
        wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      end
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: ;
      endcase
    end
  end

  AST_PW_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R10
  AST_PW_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty); // R5
endmodule

// File: rtl/boq_delay_table.sv
module boq_delay_table
  import boq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW    = 3,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  desc_t             req,
  input  logic [CW-1:0]     pw_count,
  input  logic              pw_pop,
  output logic              done_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              iss_valid,
  output desc_t             iss_desc,
  input  logic              iss_take,
  input  logic              cpl_valid,
  input  logic [DATA_W-1:0] cpl_data,
  input  logic              cpl_err
);
  desc_t             ent [DEPTH];
  slot_e             st  [DEPTH];
  logic [CW-1:0]     bar [DEPTH];
  logic [DATA_W-1:0] rd  [DEPTH];
  logic              er  [DEPTH];
  logic [IW-1:0]     ord [DEPTH];
  logic [IW-1:0]     oh, ot, bidx, hidx, fidx;
  logic [IW:0]       ocnt;
  logic              busy, hit, fre, alloc;

  // Associative match on a repeat, and lowest free slot for a new request.
  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    fre  = 1'b0;
    fidx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!hit && st[i] != ST_FREE && ent[i].cmd == req.cmd &&
          ent[i].addr == req.addr && ent[i].be == req.be) begin
        hit  = 1'b1;
        hidx = IW'(i);
      end
      if (!fre && st[i] == ST_FREE) begin
        fre  = 1'b1;
        fidx = IW'(i);
      end
    end
  end

  assign done_hit  = req_valid && hit && st[hidx] == ST_DONE;
  assign alloc     = req_valid && !hit && fre;
  assign rsp_data  = rd[hidx];
  assign rsp_err   = er[hidx];
  assign iss_valid = !busy && ocnt != '0 && bar[ord[oh]] == '0;
  assign iss_desc  = ent[ord[oh]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st[i]  <= ST_FREE;
        bar[i] <= '0;
      end
      oh   <= '0;
      ot   <= '0;
      ocnt <= '0;
      busy <= 1'b0;
      bidx <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (pw_pop && bar[i] != '0) bar[i] <= bar[i] - CW'(1);
      if (alloc) begin
        ent[fidx] <= req;
        st[fidx]  <= ST_PEND;
        bar[fidx] <= pw_count - CW'(pw_pop);
        ord[ot]   <= fidx;
        ot        <= (ot == IW'(DEPTH - 1)) ? '0 : ot + IW'(1);
      end
      if (iss_take) begin
        st[ord[oh]] <= ST_ISSUED;
        busy        <= 1'b1;
        bidx        <= ord[oh];
        oh          <= (oh == IW'(DEPTH - 1)) ? '0 : oh + IW'(1);
      end
      if (cpl_valid && busy) begin
        st[bidx] <= ST_DONE;
        rd[bidx] <= cpl_data;
        er[bidx] <= cpl_err;
        busy     <= 1'b0;
      end
      if (done_hit) st[hidx] <= ST_FREE;
      case ({alloc, iss_take})
        2'b10:   ocnt <= ocnt + (IW+1)'(1);
        2'b01:   ocnt <= ocnt - (IW+1)'(1);
        default: ;
      endcase
    end
  end

  AST_CPL_BEHIND_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |-> bar[hidx] == '0); // R6
  AST_DONE_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |=> st[$past(hidx)] == ST_FREE); // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    iss_take |-> !busy); // R13
  AST_ORDER_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> ocnt < (IW+1)'(DEPTH)); // R11
endmodule

// File: rtl/bridge_order_queue.sv
module bridge_order_queue
  import boq_pkg::*;
#(
  parameter int PW_DEPTH  = 4,
  parameter int DLY_DEPTH = 4,
  localparam int CW = $clog2(PW_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_cmd,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BE_W-1:0]   in_be,
  input  logic [DATA_W-1:0] in_data,
  output logic [1:0]        in_resp,
  output logic [DATA_W-1:0] in_rdata,
  output logic              in_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_cmd,
  output logic [ADDR_W-1:0] out_addr,
  output logic [BE_W-1:0]   out_be,
  output logic [DATA_W-1:0] out_data,
  input  logic              cpl_valid,
  input  logic [DATA_W-1:0] cpl_data,
  input  logic              cpl_err
);
  desc_t             in_d, pw_head, dly_desc, sel_d;
  logic              is_posted, is_delayed;
  logic              pw_push, pw_pop, pw_nonempty, pw_full;
  logic [CW-1:0]     pw_count;
  logic              dly_done, dly_iss_valid, dly_take, sel_dly, pw_hold, take;
  logic [DATA_W-1:0] dly_data;
  logic              dly_err;
  rsp_e              rsp;

  assign in_d = '{cmd: in_cmd, addr: in_addr, be: in_be, data: in_data};

  boq_classify u_cls (
    .cmd(in_cmd), .is_posted(is_posted), .is_delayed(is_delayed)
  );

  assign pw_push = in_valid && is_posted && !pw_full;

  boq_post_fifo #(.DEPTH(PW_DEPTH)) u_pw (
    .clk(clk), .rst_n(rst_n), .push(pw_push), .push_d(in_d), .pop(pw_pop),
    .nonempty(pw_nonempty), .full(pw_full), .head(pw_head), .count(pw_count)
  );

  boq_delay_table #(.DEPTH(DLY_DEPTH), .CW(CW)) u_dly (
    .clk(clk), .rst_n(rst_n), .req_valid(in_valid && is_delayed), .req(in_d),
    .pw_count(pw_count), .pw_pop(pw_pop), .done_hit(dly_done),
    .rsp_data(dly_data), .rsp_err(dly_err), .iss_valid(dly_iss_valid),
    .iss_desc(dly_desc), .iss_take(dly_take), .cpl_valid(cpl_valid),
    .cpl_data(cpl_data), .cpl_err(cpl_err)
  );

  // Initiator-side answer.
  always_comb begin
    rsp = RSP_NONE;
    if (in_valid && is_posted)  rsp = pw_full  ? RSP_RETRY : RSP_ACCEPT;
    if (in_valid && is_delayed) rsp = dly_done ? RSP_DONE  : RSP_RETRY;
  end
  assign in_resp  = rsp;
  assign in_rdata = dly_done ? dly_data : '0;
  assign in_err   = dly_done && dly_err;

  // Target-side selection: an eligible delayed request is older than every
  // queued posted write, except that a stalled posted head keeps the port.
  assign sel_dly   = dly_iss_valid && !pw_hold;
  assign out_valid = sel_dly || pw_nonempty;
  assign sel_d     = sel_dly ? dly_desc : pw_head;
  assign out_cmd   = sel_d.cmd;
  assign out_addr  = sel_d.addr;
  assign out_be    = sel_d.be;
  assign out_data  = sel_d.data;
  assign take      = out_valid && out_ready;
  assign dly_take  = take && sel_dly;
  assign pw_pop    = take && !sel_dly;

  always_ff @(posedge clk) begin
    if (!rst_n) pw_hold <= 1'b0;
    else        pw_hold <= out_valid && !out_ready && !sel_dly;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_cmd) && $stable(out_addr)
      && $stable(out_be) && $stable(out_data)); // R12
  AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pw_push |-> !dly_done); // R1
endmodule

// File: tb/bridge_order_queue_tb_top.sv
module bridge_order_queue_tb_top;
  import boq_pkg::*;

  localparam logic [3:0] C_MW = 4'h7, C_MWI = 4'hF, C_IOW = 4'h3, C_CFW = 4'hB;
  localparam logic [3:0] C_IOR = 4'h2, C_MR = 4'h6, C_SPC = 4'h1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, in_valid, in_err, out_valid, out_ready, cpl_valid, cpl_err;
  logic [3:0]        in_cmd, out_cmd;
  logic [ADDR_W-1:0] in_addr, out_addr;
  logic [BE_W-1:0]   in_be, out_be;
  logic [DATA_W-1:0] in_data, in_rdata, out_data, cpl_data;
  logic [1:0]        in_resp;

  int vec = 0;
  int bad = 0;

  bridge_order_queue dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cmd(in_cmd), .in_addr(in_addr),
    .in_be(in_be), .in_data(in_data), .in_resp(in_resp), .in_rdata(in_rdata),
    .in_err(in_err), .out_valid(out_valid), .out_ready(out_ready), .out_cmd(out_cmd),
    .out_addr(out_addr), .out_be(out_be), .out_data(out_data), .cpl_valid(cpl_valid),
    .cpl_data(cpl_data), .cpl_err(cpl_err)
  );

  function automatic void chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; cpl_valid = 1'b0;
    in_cmd = '0; in_addr = '0; in_be = '0; in_data = '0; cpl_data = '0; cpl_err = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(string req, logic [3:0] c, logic [31:0] a, logic [3:0] b,
                      logic [31:0] d, logic [1:0] exp_rsp);
    @(negedge clk);
    in_valid = 1'b1; in_cmd = c; in_addr = a; in_be = b; in_data = d;
    #1;
    chk(req, "in_resp", in_resp, exp_rsp);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_done(string req, logic [3:0] c, logic [31:0] a, logic [3:0] b,
                           logic [31:0] exp_d, logic exp_e);
    @(negedge clk);
    in_valid = 1'b1; in_cmd = c; in_addr = a; in_be = b; in_data = '0;
    #1;
    chk(req, "in_resp done", in_resp, 2'b11);
    chk(req, "in_rdata", in_rdata, exp_d);
    chk(req, "in_err", in_err, exp_e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic peek(string req, logic [3:0] c, logic [31:0] a, logic [3:0] b, logic [31:0] d);
    chk(req, "out_valid", out_valid, 1'b1);
    chk(req, "out_cmd/addr", {out_cmd, out_addr}, {c, a});
    chk(req, "out_be/data", {out_be, out_data}, {b, d});
  endtask

  task automatic pull(string req, logic [3:0] c, logic [31:0] a, logic [3:0] b, logic [31:0] d);
    @(negedge clk);
    peek(req, c, a, b, d);
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic complete(logic [31:0] d, logic e);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_data = d; cpl_err = e;
    @(posedge clk);
    #1 cpl_valid = 1'b0;
  endtask

  task automatic expect_idle(string req);
    @(negedge clk);
    chk(req, "out_valid idle", out_valid, 1'b0);
  endtask

  task automatic t_classify();
    do_reset();
    @(negedge clk);
    chk("R12", "reset out_valid", out_valid, 1'b0);
    chk("R4", "idle in_resp", in_resp, 2'b00);
    send("R1", C_MW,  32'h100, 4'hF, 32'h11, 2'b01);
    send("R1", C_MWI, 32'h140, 4'hF, 32'h12, 2'b01);
    send("R2", C_IOW, 32'h200, 4'h1, 32'h22, 2'b10);
    send("R2", C_CFW, 32'h300, 4'hF, 32'h33, 2'b10);
    send("R3", C_MR,  32'h400, 4'hF, 32'h0,  2'b10);
    send("R4", C_SPC, 32'h500, 4'hF, 32'h0,  2'b00);
    pull("R5", C_MW,  32'h100, 4'hF, 32'h11);
    pull("R5", C_MWI, 32'h140, 4'hF, 32'h12);
    pull("R6", C_IOW, 32'h200, 4'h1, 32'h22);
    expect_idle("R13");
    complete(32'h0, 1'b0);
    pull("R6", C_CFW, 32'h300, 4'hF, 32'h33);
    complete(32'h0, 1'b1);
    pull("R6", C_MR, 32'h400, 4'hF, 32'h0);
    complete(32'hDEAD, 1'b0);
    expect_idle("R4");
    send_done("R8", C_IOW, 32'h200, 4'h1, 32'h0, 1'b0);
    send_done("R8", C_CFW, 32'h300, 4'hF, 32'h0, 1'b1);
    send_done("R8", C_MR,  32'h400, 4'hF, 32'hDEAD, 1'b0);
    send("R8", C_MR, 32'h400, 4'hF, 32'h0, 2'b10);
  endtask

  task automatic t_order();
    do_reset();
    send("R3", C_MR, 32'h500, 4'hF, 32'h0, 2'b10);
    send("R7", C_MW, 32'h510, 4'hF, 32'h51, 2'b01);
    send("R7", C_MW, 32'h520, 4'hF, 32'h52, 2'b01);
    pull("R6", C_MR, 32'h500, 4'hF, 32'h0);
    pull("R7", C_MW, 32'h510, 4'hF, 32'h51);
    pull("R5", C_MW, 32'h520, 4'hF, 32'h52);
    expect_idle("R5");
    do_reset();
    send("R1", C_MW,  32'h600, 4'hF, 32'h60, 2'b01);
    send("R3", C_IOR, 32'h610, 4'hF, 32'h0,  2'b10);
    send("R1", C_MW,  32'h620, 4'hF, 32'h62, 2'b01);
    pull("R6", C_MW,  32'h600, 4'hF, 32'h60);
    pull("R6", C_IOR, 32'h610, 4'hF, 32'h0);
    pull("R6", C_MW,  32'h620, 4'hF, 32'h62);
  endtask

  task automatic t_hold();
    do_reset();
    send("R3", C_IOR, 32'h800, 4'hF, 32'h0, 2'b10);
    pull("R13", C_IOR, 32'h800, 4'hF, 32'h0);
    send("R3", C_IOR, 32'h810, 4'hF, 32'h0, 2'b10);
    send("R7", C_MW, 32'h820, 4'hF, 32'h82, 2'b01);
    @(negedge clk);
    peek("R7", C_MW, 32'h820, 4'hF, 32'h82);
    complete(32'h5, 1'b0);
    @(negedge clk);
    peek("R12", C_MW, 32'h820, 4'hF, 32'h82);
    pull("R12", C_MW, 32'h820, 4'hF, 32'h82);
    pull("R6", C_IOR, 32'h810, 4'hF, 32'h0);
  endtask

  task automatic t_nomerge();
    do_reset();
    send("R1", C_MW,  32'h900, 4'h3, 32'h0000AAAA, 2'b01);
    send("R1", C_MW,  32'h900, 4'hC, 32'hBBBB0000, 2'b01);
    send("R1", C_MWI, 32'h904, 4'hF, 32'h12345678, 2'b01);
    pull("R5", C_MW,  32'h900, 4'h3, 32'h0000AAAA);
    pull("R5", C_MW,  32'h900, 4'hC, 32'hBBBB0000);
    pull("R5", C_MWI, 32'h904, 4'hF, 32'h12345678);
    expect_idle("R5");
  endtask

  task automatic t_pfull();
    do_reset();
    for (int i = 0; i < 4; i++)
      send("R10", C_MW, 32'hA00 + 32'(i * 4), 4'hF, 32'(i), 2'b01);
    send("R10", C_MW, 32'hA40, 4'hF, 32'h99, 2'b10);
    for (int i = 0; i < 4; i++)
      pull("R10", C_MW, 32'hA00 + 32'(i * 4), 4'hF, 32'(i));
    expect_idle("R10");
  endtask

  task automatic t_dfull();
    do_reset();
    complete(32'hBAD, 1'b1);
    for (int i = 0; i < 4; i++)
      send("R11", C_IOR, 32'hB00 + 32'(i * 4), 4'hF, 32'h0, 2'b10);
    send("R11", C_IOR, 32'hB40, 4'hF, 32'h0, 2'b10);
    send("R9", C_IOR, 32'hB00, 4'hF, 32'h0, 2'b10);
    pull("R13", C_IOR, 32'hB00, 4'hF, 32'h0);
    send("R9", C_IOR, 32'hB00, 4'hF, 32'h0, 2'b10);
    complete(32'h1234, 1'b0);
    send_done("R13", C_IOR, 32'hB00, 4'hF, 32'h1234, 1'b0);
    for (int i = 1; i < 4; i++) begin
      pull("R11", C_IOR, 32'hB00 + 32'(i * 4), 4'hF, 32'h0);
      complete(32'(i), 1'b0);
    end
    expect_idle("R9");
  endtask

  initial begin
    t_classify();
    t_order();
    t_hold();
    t_nomerge();
    t_pfull();
    t_dfull();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vec++;
    bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule